// File: doc/BRIEF.md
# Montgomery modular multiplier

This block forms the Montgomery product of two W-bit residues. Given operands `opA` and `opB`, both already in Montgomery form and below an odd modulus `m`, and the constant `m'` with `m·m' ≡ −1 (mod 2^W)`, it returns `opA·opB·2^−W mod m` as a W-bit value below `m`. Because the radix is a power of two, the reduction by the radix is a bit mask and the division by it is a right shift. The block never divides by `m`.

A single digit-serial multiplier is used three times in a row. It multiplies a 2W-bit shifted multiplicand by a D-bit digit of the multiplier on each clock cycle. The three passes are:

1. The full product `t = a·b`.
2. The low W bits of `t·m'`, giving `q`.
3. The sum `t + q·m`. This pass starts with `t` already in the accumulator, so that the (2W+1)-bit carry is kept.

The top W+1 bits of that sum form `u`. The block then subtracts `m` once, using W-bit arithmetic, when the carry is set or when `u ≥ m`.

A caller presents the operands with a one-cycle `start` while `busy` is low. It then waits for the one-cycle `done` pulse, after which `result` holds its value until the next pulse.

Top module: `mont_mul`

## Requirements
- R1: For an odd modulus m, operands below m and a correct m', `result` equals opA·opB·2^−W mod m.
- R2: `result` is always below m, including moduli close to 2^W where the (2W+1)-bit sum carries out and u ≥ m.
- R3: If either operand is zero, `result` is zero.
- R4: `done` is high for exactly one cycle per operation, and `result` keeps its value from that pulse until the next pulse.
- R5: `done` is high in the cycle that begins 3·(W/D)+3 rising edges after the edge that accepts `start`.
- R6: `busy` is high from the edge that accepts `start` through the `done` cycle. A `start` while `busy` is high is ignored: it neither produces a result nor alters the one in progress.
- R7: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accepts the operands when busy is low |
| opA | input | W | First operand in Montgomery form, below modulus |
| opB | input | W | Second operand in Montgomery form, below modulus |
| modulus | input | W | Odd modulus m |
| modInv | input | W | m' = −m⁻¹ mod 2^W |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | W | Montgomery product, below modulus |

## Verification
The bench exercises three groups of corner cases.

- Moduli at both extremes: 3, and 2^W−1 with operands of m−1. A design that drops the carry of the final addition, or skips the conditional subtraction, returns a value at or above m or loses 2^W. Random odd moduli are also run.
- Zero operands. A design that mishandles the all-zero low half of the sum produces a nonzero or stale value.
- A second `start` while busy. A design that re-arms on it produces an extra `done` or corrupts the pending result.

Each result is also timed against the fixed latency and checked to hold steady after its pulse.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RUN_AB,
    S_LD_Q,
    S_RUN_Q,
    S_LD_QM,
    S_RUN_QM,
    S_FIN,
    S_DONE
  } mm_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAB;   // latch operands, clear accumulator
    logic loadQ;    // keep t, start t_lo * m'
    logic loadQM;   // seed accumulator with t, start q * m
    logic step;     // one digit of the current multiplication
    logic capture;  // conditional subtract and register result
  } mm_strobe_t;

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mm_strobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mm_state_e state, nextState;
  logic [CW-1:0] cnt;
  logic lastStep;

  assign lastStep = (cnt == LAST);

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadAB = 1'b1;
          nextState = S_RUN_AB;
        end
      end
      S_RUN_AB: begin
        strb.step = 1'b1;
        if (lastStep) nextState = S_LD_Q;
      end
      S_LD_Q: begin
        strb.loadQ = 1'b1;
        nextState = S_RUN_Q;
      end
      S_RUN_Q: begin
        strb.step = 1'b1;
        if (lastStep) nextState = S_LD_QM;
      end
      S_LD_QM: begin
        strb.loadQM = 1'b1;
        nextState = S_RUN_QM;
      end
      S_RUN_QM: begin
        strb.step = 1'b1;
        if (lastStep) nextState = S_FIN;
      end
      S_FIN: begin
        strb.capture = 1'b1;
        nextState = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (strb.step) cnt <= lastStep ? '0 : cnt + 1'b1;
      else           cnt <= '0;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R4: the completion pulse lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done held longer than one cycle");

  // R6: once started, busy stays high until the done cycle
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy) else $error("busy dropped before done");

  // R6: a start seen while busy never reloads the operands
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> !$rose(strb.loadAB)) else $error("reload while busy");

endmodule

// File: rtl/mont_dp.sv
module mont_dp
  import mont_pkg::*;
#(
  parameter int W = 64,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  mm_strobe_t   strb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] modInv,
  output logic [W-1:0] result
);

  localparam int AW = 2 * W + 1;  // accumulator keeps the carry
  localparam int PW = 2 * W + D;  // full digit product width

  logic [2*W-1:0] mcand;
  logic [W-1:0]   mplier;
  logic [AW-1:0]  acc;
  logic [2*W-1:0] tReg;
  logic [W-1:0]   mReg;
  logic [W-1:0]   mpReg;
  logic [W-1:0]   resReg;

  logic [D-1:0]   digit;
  logic [PW-1:0]  prodFull;
  logic [AW-1:0]  addend;

  // Digit-serial partial product
  always_comb begin
    digit    = mplier[D-1:0];
    prodFull = {{D{1'b0}}, mcand} * {{(2*W){1'b0}}, digit};
    addend   = prodFull[AW-1:0];
  end

  // Final reduction: u = acc >> W, subtract m once if needed
  logic [W-1:0] uLo;
  logic [W-1:0] diff;
  logic         carry;
  logic         geM;
  logic [W-1:0] finalVal;

  always_comb begin
    uLo      = acc[2*W-1:W];
    carry    = acc[2*W];
    geM      = carry || (uLo >= mReg);
    diff     = uLo - mReg;
    finalVal = geM ? diff : uLo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      tReg   <= '0;
      mReg   <= '0;
      mpReg  <= '0;
      resReg <= '0;
    end else begin
      if (strb.loadAB) begin
        mcand  <= {{W{1'b0}}, opA};
        mplier <= opB;
        acc    <= '0;
        mReg   <= modulus;
        mpReg  <= modInv;
      end
      if (strb.loadQ) begin
        tReg   <= acc[2*W-1:0];
        mcand  <= {{W{1'b0}}, acc[W-1:0]};
        mplier <= mpReg;
        acc    <= '0;
      end
      if (strb.loadQM) begin
        mcand  <= {{W{1'b0}}, acc[W-1:0]};
        mplier <= mReg;
        acc    <= {1'b0, tReg};
      end
      if (strb.step) begin
        acc    <= acc + addend;
        mcand  <= mcand << D;
        mplier <= mplier >> D;
      end
      if (strb.capture) resReg <= finalVal;
    end
  end

  assign result = resReg;

  // R1: the reduction sum is a multiple of the radix when reduced
  p_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (acc[W-1:0] == '0)) else $error("low half of reduction sum nonzero");

  // R2: the registered result lies below the modulus
  p_result_below_m_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (resReg < mReg)) else $error("result not below modulus");

  // R4: the result only changes on a capture
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(resReg)) else $error("result changed without capture");

endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mont_pkg::*;
#(
  parameter int W = 64,
  parameter int D = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] modInv,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  // D must divide W
  localparam int STEPS = W / D;

  mm_strobe_t strb;

  mont_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  mont_dp #(.W(W), .D(D)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .modulus (modulus),
    .modInv  (modInv),
    .result  (result)
  );

endmodule

// File: tb/mont_mul_bench.sv
module mont_mul_bench;

  localparam int W   = 64;
  localparam int D   = 16;
  localparam int LAT = 3 * (W / D) + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN;
  logic         start;
  logic [W-1:0] opA, opB, modulus, modInv;
  logic         busy, done;
  logic [W-1:0] result;

  mont_mul #(.W(W), .D(D)) u_mont_mul (
    .clk(clk), .rstN(rstN), .start(start),
    .opA(opA), .opB(opB), .modulus(modulus), .modInv(modInv),
    .busy(busy), .done(done), .result(result)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [W-1:0] expv;
    int unsigned  cyc0;
  } item_t;
  item_t sb[$];

  int nChk = 0, nFail = 0, nDone = 0, nIssued = 0;
  logic [W-1:0] lastRes = '0;
  bit chkDrop = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  // m' = -m^-1 mod 2^W by Newton iteration
  function automatic logic [W-1:0] negInv(input logic [W-1:0] m);
    logic [W-1:0] x = m;
    for (int i = 0; i < 7; i++) x = x * (2 - m * x);
    return -x;
  endfunction

  // a*b mod m, then halve mod m W times
  function automatic logic [W-1:0] refMont(input logic [W-1:0] a, b, m);
    logic [2*W-1:0] p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    logic [2*W-1:0] r = p % {{W{1'b0}}, m};
    logic [W:0] x = r[W:0];
    for (int i = 0; i < W; i++) begin
      if (x[0]) x = (x + {1'b0, m}) >> 1;
      else      x = x >> 1;
    end
    return x[W-1:0];
  endfunction

  task automatic runOp(input logic [W-1:0] a, b, m);
    item_t it;
    while (busy) @(negedge clk);
    check(result == lastRes, "R4 result held between ops", result, lastRes);
    opA = a; opB = b; modulus = m; modInv = negInv(m);
    start = 1'b1;
    it.expv = refMont(a, b, m);
    it.cyc0 = cyc + 1;
    sb.push_back(it);
    nIssued++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (chkDrop) begin
      check(!done, "R4 done single cycle", W'(done), '0);
      chkDrop = 0;
    end
    if (rstN && done) begin
      item_t it;
      nDone++;
      chkDrop = 1;
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected done", result, '0);
      end else begin
        it = sb.pop_front();
        check(result == it.expv, "R1 R2 R3 result value", result, it.expv);
        check(cyc == it.cyc0 + LAT, "R5 latency", W'(cyc - it.cyc0), W'(LAT));
        lastRes = result;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog timeout", '0, '0);
    summary();
  end

  initial begin
    logic [W-1:0] m, a, b;
    rstN = 1'b0; start = 1'b0;
    opA = '0; opB = '0; modulus = 3; modInv = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset state
    check(!busy, "R7 busy after reset", W'(busy), '0);
    check(!done, "R7 done after reset", W'(done), '0);
    check(result == '0, "R7 result after reset", result, '0);

    // R3: zero operands
    runOp('0, 64'h1234_5678_9abc_def0, 64'hffff_ffff_ffff_ffc5);
    runOp(64'h42, '0, 64'h8000_0000_0000_0001);
    runOp('0, '0, 3);

    // R2: extreme moduli and operands at m-1
    m = '1;
    runOp(m - 1, m - 1, m);
    runOp(m - 2, m - 1, m);
    runOp(2, 1, 3);
    runOp(1, 1, 3);
    m = 64'hffff_ffff_ffff_ff61;
    runOp(m - 1, m - 3, m);

    // R6: start while busy is ignored
    runOp(64'h1111, 64'h2222, 64'hdead_beef_0000_0001);
    repeat (3) @(negedge clk);
    check(busy, "R6 busy during op", W'(busy), 1);
    opA = 64'h7; opB = 64'h9; modulus = 64'hb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // R1: random odd moduli
    for (int i = 0; i < 20; i++) begin
      m = {$urandom, $urandom} | 64'h1;
      if (m == 1) m = 3;
      a = {$urandom, $urandom} % m;
      b = {$urandom, $urandom} % m;
      runOp(a, b, m);
    end

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(nDone == nIssued, "R6 done count equals accepted starts",
          W'(nDone), W'(nIssued));
    check(result == lastRes, "R4 result held after last op", result, lastRes);
    summary();
  end

endmodule